// File: doc/BRIEF.md
# Single-Cycle RISC Core

This block is a small processor core. Each instruction is fetched, decoded, executed and written back within one clock period. The program counter, a sixteen-entry register file and the external data memory are the only state that changes on the clock edge. Everything else is combinational: the decoder, the ALU, the sign extension and the datapath selectors.

The core uses two memory ports. The fetch port presents the program counter as a byte address and takes back the 32-bit instruction in the same cycle. The data port presents an address, store data and a write strobe, and takes back load data in the same cycle.

Instructions are 32 bits wide and share one field layout:

| Bits | Field |
|---|---|
| 31:28 | major opcode |
| 27:24 | minor opcode |
| 23:20 | field D |
| 19:16 | field S |
| 15:12 | field T |
| 15:0 | signed immediate |

Field T and the immediate overlap. Register-form instructions use field T, and all other forms use the immediate.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0 and clears all sixteen 32-bit registers. While reset is held, `imem_addr` reads 0 from the next cycle on.
- R2: `imem_addr` always equals the program counter. Every instruction that is not a taken branch and not a jump-and-link advances the program counter by 4.
- R3: Major opcode 0 is the register ALU form. It writes reg[D] = f(reg[S], reg[T]), where f is chosen by the minor opcode: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right, 7 arithmetic shift right. Shift amounts come from the low 5 bits of the second operand.
- R4: Major opcode 1 is the immediate ALU form. It writes reg[D] = f(reg[S], sign-extended immediate), using the same function codes as R3.
- R5: Major opcode 2 is the word load. It drives `dmem_addr` = reg[S] + sign-extended immediate and writes `dmem_rdata` into reg[D].
- R6: Major opcode 3 is the word store. It raises `dmem_we` for that one cycle, with `dmem_addr` = reg[S] + sign-extended immediate and `dmem_wdata` = reg[D]. It writes no register. `dmem_we` is low for every other opcode.
- R7: Major opcode 4 is the conditional branch. The ALU applies the minor-opcode function to reg[S] and reg[D]. If bit 0 of the result is 1, the program counter becomes PC+4+4*immediate. Otherwise it becomes PC+4. No register or memory is written.
- R8: Major opcode 5 is the jump-and-link. It writes PC+4 into reg[D] and sets the program counter to reg[S] + 4*immediate.
- R9: Major opcodes 6 to 15 write no register and no memory, and advance the program counter by 4.
- R10: Minor opcodes 8 to 12 are compares that yield 1 or 0: 8 equal, 9 not equal, 10 signed less-than, 11 signed less-or-equal, 12 unsigned less-than. Any other minor opcode yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Fetch byte address (program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data byte address (ALU result) |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written on the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |

## Verification
The data-port outputs depend combinationally on the current program counter, the registers and the instruction word. A store's address, data and strobe are therefore due in the same cycle in which its instruction is fetched. The effects of that instruction become visible one rising edge later: the next fetch address, register contents (observed through later stores) and memory contents.

The bench compares every port at the falling edge following each rising edge. It walks a table holding the expected fetch address and store activity for every executed instruction. After the run it checks the memory words, and a second reset confirms the program counter returns to zero on the next edge.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int INSN_W = 32;
    localparam int FLD_W  = 4;
    localparam int IMM_W  = 16;

    typedef enum logic [3:0] {
        OPC_ALUR = 4'h0,
        OPC_ALUI = 4'h1,
        OPC_LDW  = 4'h2,
        OPC_STW  = 4'h3,
        OPC_BCC  = 4'h4,
        OPC_JLNK = 4'h5
    } opc_e;

    typedef enum logic [4:0] {
        FN_ADD = 5'h00,
        FN_SUB = 5'h01,
        FN_AND = 5'h02,
        FN_OR  = 5'h03,
        FN_XOR = 5'h04,
        FN_SLL = 5'h05,
        FN_SRL = 5'h06,
        FN_SRA = 5'h07,
        FN_EQ  = 5'h08,
        FN_NE  = 5'h09,
        FN_LT  = 5'h0A,
        FN_LE  = 5'h0B,
        FN_LTU = 5'h0C
    } alu_fn_e;

    typedef enum logic [1:0] {
        WB_ALU  = 2'd0,
        WB_MEM  = 2'd1,
        WB_LINK = 2'd2
    } wb_sel_e;

    typedef struct packed {
        logic       wr_reg;
        logic       wr_mem;
        logic       is_branch;
        logic       is_jump;
        logic       use_imm;
        logic       rb_from_d;
        wb_sel_e    wb_sel;
        logic [4:0] alu_fn;
    } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
    import sc_pkg::*;
(
    input  logic [3:0] major_i,
    input  logic [3:0] minor_i,
    output ctrl_t      ctrl_o
);

    always_comb begin
        ctrl_o        = '0;
        ctrl_o.wb_sel = WB_ALU;
        ctrl_o.alu_fn = {1'b0, minor_i};
        case (major_i)
            OPC_ALUR: begin
                ctrl_o.wr_reg = 1'b1;
            end
            OPC_ALUI: begin
                ctrl_o.wr_reg  = 1'b1;
                ctrl_o.use_imm = 1'b1;
            end
            OPC_LDW: begin
                ctrl_o.wr_reg  = 1'b1;
                ctrl_o.use_imm = 1'b1;
                ctrl_o.wb_sel  = WB_MEM;
                ctrl_o.alu_fn  = FN_ADD;
            end
            OPC_STW: begin
                ctrl_o.wr_mem    = 1'b1;
                ctrl_o.use_imm   = 1'b1;
                ctrl_o.rb_from_d = 1'b1;
                ctrl_o.alu_fn    = FN_ADD;
            end
            OPC_BCC: begin
                ctrl_o.is_branch = 1'b1;
                ctrl_o.rb_from_d = 1'b1;
            end
            OPC_JLNK: begin
                ctrl_o.is_jump = 1'b1;
                ctrl_o.wr_reg  = 1'b1;
                ctrl_o.wb_sel  = WB_LINK;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [4:0]   fn_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);

    localparam int SH_W = $clog2(W);

    logic [SH_W-1:0] sh;
    logic            flag;
    logic            is_cmp;

    assign sh = b_i[SH_W-1:0];

    always_comb begin
        flag   = 1'b0;
        is_cmp = 1'b1;
        y_o    = '0;
        case (fn_i)
            FN_ADD: begin y_o = a_i + b_i;                    is_cmp = 1'b0; end
            FN_SUB: begin y_o = a_i - b_i;                    is_cmp = 1'b0; end
            FN_AND: begin y_o = a_i & b_i;                    is_cmp = 1'b0; end
            FN_OR:  begin y_o = a_i | b_i;                    is_cmp = 1'b0; end
            FN_XOR: begin y_o = a_i ^ b_i;                    is_cmp = 1'b0; end
            FN_SLL: begin y_o = a_i << sh;                    is_cmp = 1'b0; end
            FN_SRL: begin y_o = a_i >> sh;                    is_cmp = 1'b0; end
            FN_SRA: begin y_o = W'($signed(a_i) >>> sh);      is_cmp = 1'b0; end
            FN_EQ:  flag = (a_i == b_i);
            FN_NE:  flag = (a_i != b_i);
            FN_LT:  flag = ($signed(a_i) <  $signed(b_i));
            FN_LE:  flag = ($signed(a_i) <= $signed(b_i));
            FN_LTU: flag = (a_i < b_i);
            default: flag = 1'b0;
        endcase
        if (is_cmp) begin
            y_o = {{(W-1){1'b0}}, flag};
        end
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_addr_i,
    input  logic [AW-1:0] rb_addr_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [W-1:0]  wr_data_i,
    input  logic          wr_en_i,
    output logic [W-1:0]  ra_data_o,
    output logic [W-1:0]  rb_data_o
);

    logic [W-1:0] regs_q [NREG];
    logic [W-1:0] regs_d [NREG];

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            regs_d[wr_addr_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ra_data_o = regs_q[ra_addr_i];
    assign rb_data_o = regs_q[rb_addr_i];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DATA_W-1:0] imem_addr,
    input  logic [INSN_W-1:0] imem_rdata,
    output logic [DATA_W-1:0] dmem_addr,
    output logic [DATA_W-1:0] dmem_wdata,
    output logic              dmem_we,
    input  logic [DATA_W-1:0] dmem_rdata
);

    localparam int NREG = 1 << FLD_W;
    localparam int EXT_W = DATA_W - IMM_W;

    typedef struct packed {
        logic [DATA_W-1:0] pc;
    } core_state_t;

    core_state_t st_d, st_q;

    logic [3:0]       major, minor;
    logic [FLD_W-1:0] fld_d, fld_s, fld_t, rb_addr;
    logic [IMM_W-1:0] imm;
    ctrl_t            ctrl;

    logic [DATA_W-1:0] imm_sext, ra_val, rb_val, alu_b, alu_y;
    logic [DATA_W-1:0] pc_plus4, br_target, jl_target, wb_val;

    assign major = imem_rdata[31:28];
    assign minor = imem_rdata[27:24];
    assign fld_d = imem_rdata[23:20];
    assign fld_s = imem_rdata[19:16];
    assign fld_t = imem_rdata[15:12];
    assign imm   = imem_rdata[15:0];

    assign imm_sext = {{EXT_W{imm[IMM_W-1]}}, imm};

    sc_decoder u_dec (
        .major_i (major),
        .minor_i (minor),
        .ctrl_o  (ctrl)
    );

    assign rb_addr = ctrl.rb_from_d ? fld_d : fld_t;

    sc_regfile #(
        .W    (DATA_W),
        .NREG (NREG)
    ) u_rf (
        .clk       (clk),
        .rst       (rst),
        .ra_addr_i (fld_s),
        .rb_addr_i (rb_addr),
        .wr_addr_i (fld_d),
        .wr_data_i (wb_val),
        .wr_en_i   (ctrl.wr_reg),
        .ra_data_o (ra_val),
        .rb_data_o (rb_val)
    );

    assign alu_b = ctrl.use_imm ? imm_sext : rb_val;

    sc_alu #(
        .W (DATA_W)
    ) u_alu (
        .fn_i (ctrl.alu_fn),
        .a_i  (ra_val),
        .b_i  (alu_b),
        .y_o  (alu_y)
    );

    assign pc_plus4  = st_q.pc + DATA_W'(4);
    assign br_target = pc_plus4 + (imm_sext << 2);
    assign jl_target = ra_val + (imm_sext << 2);

    always_comb begin
        case (ctrl.wb_sel)
            WB_MEM:  wb_val = dmem_rdata;
            WB_LINK: wb_val = pc_plus4;
            default: wb_val = alu_y;
        endcase
    end

    always_comb begin
        st_d    = st_q;
        st_d.pc = pc_plus4;
        if (ctrl.is_branch && alu_y[0]) begin
            st_d.pc = br_target;
        end
        if (ctrl.is_jump) begin
            st_d.pc = jl_target;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign imem_addr  = st_q.pc;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rb_val;
    assign dmem_we    = ctrl.wr_mem;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_i,
    input logic [3:0]  major_i,
    input logic [15:0] imm_i,
    input logic        we_i
);

    logic [31:0] offs4;
    assign offs4 = {{14{imm_i[15]}}, imm_i, 2'b00};

    p_pc_reset_r1: assert property (@(posedge clk)
        rst |=> (pc_i == 32'd0));

    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (major_i <= 4'd3) |=> (pc_i == $past(pc_i) + 32'd4));

    p_store_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        we_i == (major_i == 4'd3));

    p_branch_target_r7: assert property (@(posedge clk) disable iff (rst)
        (major_i == 4'd4) |=> ((pc_i == $past(pc_i) + 32'd4) ||
                               (pc_i == $past(pc_i) + 32'd4 + $past(offs4))));

    p_unknown_step_r9: assert property (@(posedge clk) disable iff (rst)
        (major_i >= 4'd6) |=> (pc_i == $past(pc_i) + 32'd4));

    p_unknown_nowr_r9: assert property (@(posedge clk) disable iff (rst)
        (major_i >= 4'd6) |-> !we_i);

endmodule

bind sc_core sc_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc_i    (imem_addr),
    .major_i (imem_rdata[31:28]),
    .imm_i   (imem_rdata[15:0]),
    .we_i    (dmem_we)
);

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sc_core dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    // Program: major, minor, D, S, then T or the 16-bit immediate
    localparam int NPROG = 26;
    localparam logic [31:0] PROG [NPROG] = '{
        32'h10100005, // 00 addi r1 = r0 + 5
        32'h1020FFFD, // 04 addi r2 = r0 - 3
        32'h00312000, // 08 add  r3 = r1 + r2
        32'h30300008, // 0C st   r3 -> 8(r0)
        32'h01421000, // 10 sub  r4 = r2 - r1
        32'h3040000C, // 14 st   r4 -> 12(r0)
        32'h20500004, // 18 ld   r5 <- 4(r0)
        32'h146500FF, // 1C xori r6 = r5 ^ 0xFF
        32'h3061000B, // 20 st   r6 -> 11(r1)
        32'h4A120002, // 24 br lt(r2,r1) +2 (taken)
        32'h10700063, // 28 skipped
        32'h10700063, // 2C skipped
        32'h4C120005, // 30 br ltu(r2,r1) (not taken)
        32'h50800010, // 34 jal r8, r0+0x40
        32'h10700063, // 38 skipped
        32'h10700063, // 3C skipped
        32'h30800014, // 40 st   r8 -> 20(r0)
        32'h49110003, // 44 br ne(r1,r1) (not taken)
        32'h1033FFFF, // 48 addi r3 = r3 - 1
        32'h4903FFFE, // 4C br ne(r3,r0) -2
        32'h30300018, // 50 st   r3 -> 24(r0)
        32'hFFF00001, // 54 unknown major opcode
        32'h30F0001C, // 58 st   r15 -> 28(r0)
        32'h05911000, // 5C sll  r9 = r1 << r1
        32'h30900020, // 60 st   r9 -> 32(r0)
        32'h50A00019  // 64 jal r10, r0+0x64 (self loop)
    };

    // Expected trace per cycle: {pc, store strobe, address, data}
    localparam int NTR = 25;
    localparam logic [96:0] TRACE [NTR] = '{
        {32'h00, 1'b0, 32'h00, 32'h0},
        {32'h04, 1'b0, 32'h00, 32'h0},
        {32'h08, 1'b0, 32'h00, 32'h0},
        {32'h0C, 1'b1, 32'h08, 32'h2},
        {32'h10, 1'b0, 32'h00, 32'h0},
        {32'h14, 1'b1, 32'h0C, 32'hFFFFFFF8},
        {32'h18, 1'b0, 32'h00, 32'h0},
        {32'h1C, 1'b0, 32'h00, 32'h0},
        {32'h20, 1'b1, 32'h10, 32'h12345687},
        {32'h24, 1'b0, 32'h00, 32'h0},
        {32'h30, 1'b0, 32'h00, 32'h0},
        {32'h34, 1'b0, 32'h00, 32'h0},
        {32'h40, 1'b1, 32'h14, 32'h38},
        {32'h44, 1'b0, 32'h00, 32'h0},
        {32'h48, 1'b0, 32'h00, 32'h0},
        {32'h4C, 1'b0, 32'h00, 32'h0},
        {32'h48, 1'b0, 32'h00, 32'h0},
        {32'h4C, 1'b0, 32'h00, 32'h0},
        {32'h50, 1'b1, 32'h18, 32'h0},
        {32'h54, 1'b0, 32'h00, 32'h0},
        {32'h58, 1'b1, 32'h1C, 32'h0},
        {32'h5C, 1'b0, 32'h00, 32'h0},
        {32'h60, 1'b1, 32'h20, 32'hA0},
        {32'h64, 1'b0, 32'h00, 32'h0},
        {32'h64, 1'b0, 32'h00, 32'h0}
    };

    logic [31:0] imem [64];
    logic [31:0] dmem [16];

    initial begin
        for (int i = 0; i < 64; i++) imem[i] = 32'hF0000000;
        for (int i = 0; i < NPROG; i++) imem[i] = PROG[i];
        for (int i = 0; i < 16; i++) dmem[i] = 32'hDEAD0000 | 32'(i);
        dmem[1] = 32'h12345678;
    end

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[5:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[5:2]] <= dmem_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pc held at reset", imem_addr, 32'h0);
        rst = 1'b0;

        // Trace walk: one row per executed instruction, sampled at falling edge
        for (int i = 0; i < NTR; i++) begin
            chk($sformatf("R2/R7/R8 pc step %0d", i), imem_addr, TRACE[i][96:65]);
            chk($sformatf("R6/R9 store strobe step %0d", i), 32'(dmem_we), 32'(TRACE[i][64]));
            if (TRACE[i][64]) begin
                chk($sformatf("R5/R6 store addr step %0d", i), dmem_addr, TRACE[i][63:32]);
                chk($sformatf("R3/R4/R5/R8/R10 store data step %0d", i), dmem_wdata, TRACE[i][31:0]);
            end
            @(posedge clk);
            @(negedge clk);
        end

        // Memory contents after the program
        chk("R3 add result word", dmem[2], 32'h2);
        chk("R3 sub result word", dmem[3], 32'hFFFFFFF8);
        chk("R4/R5 load-xori word", dmem[4], 32'h12345687);
        chk("R8 link word", dmem[5], 32'h38);
        chk("R7/R10 loop counter word", dmem[6], 32'h0);
        chk("R1/R9 untouched register word", dmem[7], 32'h0);
        chk("R3 shift word", dmem[8], 32'hA0);
        chk("R6 load source unchanged", dmem[1], 32'h12345678);

        // Reset in the middle of a run
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 pc after mid-run reset", imem_addr, 32'h0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R2 pc after first step", imem_addr, 32'h4);
        @(posedge clk);
        @(negedge clk);
        chk("R2 pc after second step", imem_addr, 32'h8);

        finish_run();
    end

endmodule